// File: doc/BRIEF.md
# Mode-Controlled Power-of-Two Clock Divider

This block sits behind a fast, reconfigurable ring oscillator and turns its clock into a slower output clock. A 3-bit divide code selects how many halving stages are active, so the output runs at the input frequency divided by 2^M for M from 0 to 7. Halving stages above the selected depth are held at zero and do not toggle. The selected stage is registered again on the fast clock, so output edges stay aligned to the source clock. With M = 0, the fast clock itself is passed through a gate whose enable is registered.

The same block also decodes a 2-bit ring-length code into enable lines for a nine-stage oscillator ring, which can run with 3, 5, 7 or 9 stages. The ring code and the divide code together give 32 operating modes. When the divide code changes, the halving chain restarts from zero and the output is forced low, so the first output pulse after the switch has its full width.

Top module: `pow2_clk_div`

## Requirements
- R1: While `rst` is high (sampled on a rising `clk` edge), `clk_out`, `ring_en` and `div_en` are all zero.
- R2: For a settled divide code M from 1 to 7, `clk_out` is periodic with a period of exactly 2^M `clk` cycles, and each high phase lasts 2^(M-1) cycles.
- R3: For a settled divide code M = 0, `clk_out` follows `clk`: one rising edge per `clk` cycle, with a high phase of half a cycle.
- R4: One `clk` edge after `div_sel` takes the value M, `div_en` has bits 0 to M-1 set and all higher bits clear (bit k enables halving stage k+1).
- R5: One `clk` edge after `ring_sel` is applied, `ring_en` enables a prefix of the ring. Code 0 sets bits 0–2, code 1 sets bits 0–4, code 2 sets bits 0–6 and code 3 sets all nine bits.
- R6: When `div_sel` changes, `clk_out` is low by the second half of the cycle after the first `clk` edge that sees the new code. For M ≥ 1, the first high pulse that follows lasts 2^(M-1) cycles and the first full period lasts 2^M cycles.
- R7: Changing `ring_sel` while the divider runs does not disturb the timing of `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 3 | Divide code M; output frequency is clk / 2^M |
| ring_sel | input | 2 | Ring-length code: 3, 5, 7 or 9 stages |
| clk_out | output | 1 | Divided output clock |
| ring_en | output | 9 | Per-stage enables for the oscillator ring |
| div_en | output | 7 | Per-stage enables for the halving chain |

## Verification
A wrong count in the halving chain appears on `clk_out` as a period or high phase that differs from 2^M or 2^(M-1) cycles. Such an error is visible at the very next output edge, so measuring periods with timestamps catches it within one output period. A wrong restart after a mode switch appears as a shortened first pulse or a short first period, which the edge-width checks detect right after the switch. Wrong enable decoding appears on `ring_en` and `div_en` one cycle after the code is applied.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;
  localparam int DEF_DIV_STAGES  = 7;
  localparam int DEF_RING_STAGES = 9;
  localparam int DEF_RSEL_W      = 2;
  localparam int RING_MIN        = 3;
  localparam int RING_STEP       = 2;

  // Mask with the lowest k bits set.
  function automatic logic [31:0] low_ones(input int k);
    if (k >= 32) return '1;
    if (k <= 0)  return '0;
    return (32'h1 << k) - 32'h1;
  endfunction

  // Number of ring stages for a ring-length code.
  function automatic int ring_len(input int code);
    return RING_MIN + RING_STEP * code;
  endfunction
endpackage

// File: rtl/ring_len_decode.sv
module ring_len_decode
  import pow2_div_pkg::*;
#(
  parameter int RING_STAGES = DEF_RING_STAGES,
  parameter int RSEL_W      = DEF_RSEL_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [RSEL_W-1:0]      ring_sel,
  output logic [RING_STAGES-1:0] ring_en
);
  logic [31:0] full_mask;

  always_comb begin
    full_mask = low_ones(ring_len(int'(ring_sel)));
  end

  always_ff @(posedge clk) begin
    if (rst) ring_en <= '0;
    else     ring_en <= full_mask[RING_STAGES-1:0];
  end

  // R5
  ring_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    (ring_en != '0) |-> ((ring_en & (ring_en + 1'b1)) == '0));
  // R5
  ring_count_chk: assert property (@(posedge clk) disable iff (rst)
    (ring_en != '0) |-> ($countones(ring_en) == 3 || $countones(ring_en) == 5 ||
                         $countones(ring_en) == 7 || $countones(ring_en) == 9));
endmodule

// File: rtl/div_mode_ctrl.sv
module div_mode_ctrl
  import pow2_div_pkg::*;
#(
  parameter int DIV_STAGES = DEF_DIV_STAGES,
  localparam int MODE_W    = $clog2(DIV_STAGES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [MODE_W-1:0]     div_sel,
  output logic [MODE_W-1:0]     cur_mode,
  output logic                  mode_chg,
  output logic [DIV_STAGES-1:0] div_en
);
  logic [31:0] sel_mask;

  always_comb begin
    mode_chg = (div_sel != cur_mode);
    sel_mask = low_ones(int'(div_sel));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode <= '0;
      div_en   <= '0;
    end else begin
      cur_mode <= div_sel;
      div_en   <= sel_mask[DIV_STAGES-1:0];
    end
  end

  // R4
  div_en_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    (div_en & (div_en + 1'b1)) == '0);
  // R4
  div_en_count_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> ($countones(div_en) == int'(cur_mode)));
endmodule

// File: rtl/halving_chain.sv
module halving_chain
  import pow2_div_pkg::*;
#(
  parameter int DIV_STAGES = DEF_DIV_STAGES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic [DIV_STAGES-1:0] stage_en,
  output logic [DIV_STAGES-1:0] cnt
);
  logic [DIV_STAGES:0] carry;

  assign carry[0] = 1'b1;

  for (genvar k = 0; k < DIV_STAGES; k++) begin : g_stage
    assign carry[k+1] = carry[k] & cnt[k];

    always_ff @(posedge clk) begin
      if (rst || clr || !stage_en[k]) cnt[k] <= 1'b0;
      else                           cnt[k] <= cnt[k] ^ carry[k];
    end

    // R4: a disabled stage stays idle
    idle_stage_chk: assert property (@(posedge clk) disable iff (rst)
      !stage_en[k] |=> !cnt[k]);
  end

  // R2: the chain wraps to zero after its last active count
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && stage_en != '0 && cnt == stage_en) |=> (cnt == '0));
endmodule

// File: rtl/tap_resample.sv
module tap_resample
  import pow2_div_pkg::*;
#(
  parameter int DIV_STAGES = DEF_DIV_STAGES,
  localparam int MODE_W    = $clog2(DIV_STAGES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mode_chg,
  input  logic [MODE_W-1:0]     req_mode,
  input  logic [MODE_W-1:0]     cur_mode,
  input  logic [DIV_STAGES-1:0] cnt,
  output logic                  tap_q,
  output logic                  pass_en
);
  logic tap_sel;

  always_comb begin
    tap_sel = 1'b0;
    for (int k = 0; k < DIV_STAGES; k++) begin
      if (int'(cur_mode) == k + 1) tap_sel = cnt[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mode_chg) tap_q <= 1'b0;
    else                 tap_q <= tap_sel;
  end

  // Gate enable moves only while clk is low, so the pass path never glitches.
  always_ff @(negedge clk) begin
    if (rst) pass_en <= 1'b0;
    else     pass_en <= (req_mode == '0) && (cur_mode == '0);
  end

  // R6
  chg_low_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !tap_q);
endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div
  import pow2_div_pkg::*;
#(
  parameter int DIV_STAGES  = DEF_DIV_STAGES,
  parameter int RING_STAGES = DEF_RING_STAGES,
  parameter int RSEL_W      = DEF_RSEL_W,
  localparam int MODE_W     = $clog2(DIV_STAGES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [MODE_W-1:0]      div_sel,
  input  logic [RSEL_W-1:0]      ring_sel,
  output logic                   clk_out,
  output logic [RING_STAGES-1:0] ring_en,
  output logic [DIV_STAGES-1:0]  div_en
);
  logic [MODE_W-1:0]     cur_mode;
  logic                  mode_chg;
  logic [DIV_STAGES-1:0] cnt;
  logic                  tap_q;
  logic                  pass_en;

  div_mode_ctrl #(.DIV_STAGES(DIV_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .div_sel(div_sel),
    .cur_mode(cur_mode), .mode_chg(mode_chg), .div_en(div_en)
  );

  halving_chain #(.DIV_STAGES(DIV_STAGES)) u_chain (
    .clk(clk), .rst(rst), .clr(mode_chg), .stage_en(div_en), .cnt(cnt)
  );

  tap_resample #(.DIV_STAGES(DIV_STAGES)) u_tap (
    .clk(clk), .rst(rst), .mode_chg(mode_chg), .req_mode(div_sel),
    .cur_mode(cur_mode), .cnt(cnt), .tap_q(tap_q), .pass_en(pass_en)
  );

  ring_len_decode #(.RING_STAGES(RING_STAGES), .RSEL_W(RSEL_W)) u_ring (
    .clk(clk), .rst(rst), .ring_sel(ring_sel), .ring_en(ring_en)
  );

  assign clk_out = (clk & pass_en) | tap_q;

  // R3: the pass path and the divided path never drive together
  path_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass_en && tap_q));
endmodule

// File: tb/pow2_clk_div_bench.sv
`timescale 1ns/1ns
module pow2_clk_div_bench;
  localparam time TCK = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] div_sel = 3'd3;
  logic [1:0] ring_sel = 2'd1;
  logic       clk_out;
  logic [8:0] ring_en;
  logic [6:0] div_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    exp_q[$];
  string tag_q[$];
  time   last_rise = 0;
  bit    have_last = 1'b0;

  always #(TCK/2) clk = ~clk;

  pow2_clk_div u_pow2_clk_div (
    .clk(clk), .rst(rst), .div_sel(div_sel), .ring_sel(ring_sel),
    .clk_out(clk_out), .ring_en(ring_en), .div_en(div_en)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: each rising output edge closes a period and is scored.
  always @(posedge clk_out) begin
    if (have_last && exp_q.size() > 0) begin
      int    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(($time - last_rise) == TCK * e, t, "output period (ns)",
          $time - last_rise, TCK * e);
    end
    last_rise = $time;
    have_last = 1'b1;
  end

  task automatic push_periods(input int m, input int count, input string tag);
    for (int i = 0; i < count; i++) begin
      exp_q.push_back(1 << m);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
  endtask

  function automatic logic [8:0] ring_expect(input int n);
    return 9'((1 << (3 + 2 * n)) - 1);
  endfunction

  task automatic run_mode(input int m, input int n);
    time t1, t2, t3;
    string ptag;
    ptag = (m == 0) ? "R3" : "R2";
    @(posedge clk); #5;
    div_sel  = 3'(m);
    ring_sel = 2'(n);
    @(posedge clk); #15;
    chk(div_en == 7'((1 << m) - 1), "R4", "div_en", div_en, (1 << m) - 1);
    chk(ring_en == ring_expect(n), "R5", "ring_en", ring_en, ring_expect(n));
    chk(clk_out == 1'b0, "R6", "clk_out low after change", clk_out, 0);
    if (m >= 1) begin
      @(posedge clk_out); t1 = $time;
      @(negedge clk_out); t2 = $time;
      @(posedge clk_out); t3 = $time;
      chk((t2 - t1) == TCK * (1 << (m - 1)), "R6", "first high pulse (ns)",
          t2 - t1, TCK * (1 << (m - 1)));
      chk((t3 - t1) == TCK * (1 << m), "R6", "first period (ns)",
          t3 - t1, TCK * (1 << m));
    end else begin
      repeat (3) @(posedge clk);
      #5;
      chk(clk_out == 1'b1, ptag, "pass high phase", clk_out, 1);
      #10;
      chk(clk_out == 1'b0, ptag, "pass low phase", clk_out, 0);
    end
    push_periods(m, 3, ptag);
    drain();
    // R7: change ring length mid-run; output timing must not move
    @(posedge clk); #5;
    ring_sel = 2'((n + 1) % 4);
    push_periods(m, 3, "R7");
    drain();
    @(posedge clk); #15;
    chk(ring_en == ring_expect((n + 1) % 4), "R5", "ring_en after change",
        ring_en, ring_expect((n + 1) % 4));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #5;
    chk(clk_out == 1'b0, "R1", "clk_out in reset (clk high)", clk_out, 0);
    #10;
    chk(clk_out == 1'b0, "R1", "clk_out in reset (clk low)", clk_out, 0);
    chk(ring_en == '0, "R1", "ring_en in reset", ring_en, 0);
    chk(div_en == '0, "R1", "div_en in reset", div_en, 0);
    @(posedge clk); #5;
    rst = 1'b0;
    for (int m = 0; m < 8; m++) run_mode(m, m % 4);
    run_mode(1, 3);
    run_mode(7, 2);
    run_mode(0, 1);
    run_mode(5, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule